// File: doc/BRIEF.md
# NOR Flash Word Program Sequencer

This block programs a single bus word into a parallel NOR flash device. A caller presents a mode, a byte address and a data word. The block enables the programming supply, writes a setup command and then the data word to the word-aligned address, and waits for a time estimate held in microseconds. After that wait it reads the device status with a fixed read latency, repeating the read once per microsecond until the ready bit appears or the poll budget is used up. If the device reports a lock violation, the block clears the status and returns the device to status-read mode before it reports.

The wait estimate adapts itself. An operation that finishes on the first status read shortens the estimate by one microsecond, with a floor of one. An operation that needs three or more reads lengthens it by one microsecond. Time is counted with a clock prescaler, so a single parameter ties the block to its clock frequency.

Top module: `nor_word_prog`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `fl_we`, `fl_re` and `vpp_en` are low, and `wwt_us` equals `WWT_INIT`.
- R2: Mode 0 (normal) uses setup command 0x40 and mode 1 (one-time-programmable) uses 0xC0. Modes 2 and 3 finish with result code 3 (invalid). They make no bus strobe, leave `vpp_en` low and leave `wwt_us` unchanged.
- R3: The first write strobe carries the setup command in the low byte, with the upper bits zero. The second carries the data word. Both go to the request address with its low log2(DW/8) bits cleared.
- R4: `vpp_en` is high during every write strobe, is raised at least one cycle before the first strobe, and is low when `done` pulses.
- R5: The first status read comes `wwt_us`×`CYC_PER_US` cycles, plus a small fixed overhead, after the data write strobe.
- R6: Status bit 7 set means ready. A read without it leads to a one-microsecond pause and another read. `fl_we` and `fl_re` are never high together.
- R7: If `TIMEOUT_US`+1 reads in a row show not-ready, the block stops with result code 1 (timeout) and leaves `wwt_us` unchanged. Ready on the last of those reads counts as a success.
- R8: When ready is seen, the estimate is updated from the number of reads. One read lowers `wwt_us` by 1, but not below 1. Two reads leave it unchanged. Three or more raise it by 1, saturating at the field maximum.
- R9: If status bit 1 is set in the ready status, the block writes 0x50 and then 0x70 to the same aligned address and ends with result code 2 (protected). The estimate is still updated as in R8.
- R10: Result code 0 means success. `done` is a one-cycle pulse. `busy` is high from acceptance until `done`. A request made while busy is ignored.
- R11: Each status value is taken from `fl_rdata` in the `READ_LAT`-th cycle after the read strobe cycle, and in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, sampled when idle |
| req_mode | input | 2 | 0 normal, 1 one-time-programmable, others invalid |
| req_addr | input | AW | Byte address of the word |
| req_data | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 protected, 3 invalid; valid with done |
| wwt_us | output | WWT_W | Current program time estimate in microseconds |
| vpp_en | output | 1 | Programming supply enable |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash status read strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |

## Verification
Two decisions can fall in the same cycle: detecting ready and running out of poll budget. The bench makes the device report not-ready for exactly `TIMEOUT_US` reads and ready on the read after that. It then expects success, `TIMEOUT_US`+1 reads and a raised estimate. A second case keeps the device busy one read longer and expects a timeout with the estimate unchanged. The estimate update and the lock decision also fall on the same sampling edge. The lock cases check both the recovery commands and the updated `wwt_us`.

// File: rtl/nwp_pkg.sv
package nwp_pkg;
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_PROTECT = 2'd2,
    RES_INVALID = 2'd3
  } nwp_result_e;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_OTP    = 2'd1;

  localparam logic [7:0] OP_PROG     = 8'h40;
  localparam logic [7:0] OP_OTP_PROG = 8'hC0;
  localparam logic [7:0] OP_CLR_STAT = 8'h50;
  localparam logic [7:0] OP_RD_STAT  = 8'h70;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_LOCK_BIT  = 1;
endpackage

// File: rtl/nwp_us_timer.sv
module nwp_us_timer #(
  parameter int CYC_PER_US = 50,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             expire_o
);
  localparam int CYC_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_US - 1);

  logic             run_q, run_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [CNT_W-1:0] us_q, us_d;
  logic             exp_q, exp_d;

  always_comb begin
    run_d = run_q;
    cyc_d = cyc_q;
    us_d  = us_q;
    exp_d = 1'b0;
    if (start_i) begin
      run_d = 1'b1;
      cyc_d = '0;
      us_d  = count_i;
    end else if (run_q) begin
      if (cyc_q == CYC_LAST) begin
        cyc_d = '0;
        if (us_q == CNT_W'(1)) begin
          run_d = 1'b0;
          exp_d = 1'b1;
        end else begin
          us_d = us_q - CNT_W'(1);
        end
      end else begin
        cyc_d = cyc_q + CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cyc_q <= '0;
      us_q  <= '0;
      exp_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cyc_q <= cyc_d;
      us_q  <= us_d;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;

  AST_TMR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (count_i != '0)); // R5
  AST_TMR_EXP_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> $past(run_q)); // R5
endmodule

// File: rtl/nwp_wwt_est.sv
module nwp_wwt_est #(
  parameter int WWT_W    = 8,
  parameter int WWT_INIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             none_i,
  input  logic             many_i,
  output logic [WWT_W-1:0] wwt_o
);
  localparam logic [WWT_W-1:0] WWT_MAX   = '1;
  localparam logic [WWT_W-1:0] WWT_RESET = WWT_W'(WWT_INIT);

  logic [WWT_W-1:0] wwt_q, wwt_d;

  always_comb begin
    wwt_d = wwt_q;
    if (upd_i) begin
      if (none_i && (wwt_q > WWT_W'(1))) begin
        wwt_d = wwt_q - WWT_W'(1);
      end else if (many_i && (wwt_q != WWT_MAX)) begin
        wwt_d = wwt_q + WWT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wwt_q <= WWT_RESET;
    end else if (upd_i) begin
      wwt_q <= wwt_d;
    end
  end

  assign wwt_o = wwt_q;

  AST_WWT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    wwt_o != '0); // R8
  AST_WWT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(wwt_o)); // R8
endmodule

// File: rtl/nor_word_prog.sv
module nor_word_prog
  import nwp_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 16,
  parameter int CYC_PER_US = 50,
  parameter int TIMEOUT_US = 500000,
  parameter int WWT_W      = 8,
  parameter int WWT_INIT   = 8,
  parameter int READ_LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic [WWT_W-1:0] wwt_us,
  output logic             vpp_en,
  output logic             fl_we,
  output logic             fl_re,
  output logic [AW-1:0]    fl_addr,
  output logic [DW-1:0]    fl_wdata,
  input  logic [DW-1:0]    fl_rdata
);
  localparam int BYTES = DW / 8;
  localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(BYTES - 1));
  localparam int Z_W   = $clog2(TIMEOUT_US + 1) + 1;
  localparam int LAT_W = $clog2(READ_LAT + 1);
  localparam logic [Z_W-1:0] Z_LIMIT = Z_W'(TIMEOUT_US);

  typedef enum logic [3:0] {
    ST_IDLE, ST_VPP, ST_SETUP, ST_DATA, ST_WAIT, ST_READ,
    ST_LAT, ST_GAP, ST_CLR, ST_RDSR, ST_FIN
  } state_e;

  state_e           state_q, state_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [DW-1:0]    data_q, data_d;
  logic [7:0]       setup_q, setup_d;
  logic [Z_W-1:0]   z_q, z_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  nwp_result_e      res_q, res_d;

  logic             tmr_start, tmr_exp, est_upd;
  logic [WWT_W-1:0] tmr_count;
  logic             stat_ready, stat_lock;

  assign stat_ready = fl_rdata[STAT_READY_BIT];
  assign stat_lock  = fl_rdata[STAT_LOCK_BIT];

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    data_d    = data_q;
    setup_d   = setup_q;
    z_d       = z_q;
    lat_d     = lat_q;
    res_d     = res_q;
    tmr_start = 1'b0;
    tmr_count = wwt_us;
    est_upd   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        if (req_mode == MODE_NORMAL || req_mode == MODE_OTP) begin
          addr_d  = req_addr & ALIGN_MASK;
          data_d  = req_data;
          setup_d = (req_mode == MODE_OTP) ? OP_OTP_PROG : OP_PROG;
          z_d     = '0;
          state_d = ST_VPP;
        end else begin
          res_d   = RES_INVALID;
          state_d = ST_FIN;
        end
      end
      ST_VPP:   state_d = ST_SETUP;
      ST_SETUP: state_d = ST_DATA;
      ST_DATA: begin
        tmr_start = 1'b1;
        state_d   = ST_WAIT;
      end
      ST_WAIT: if (tmr_exp) state_d = ST_READ;
      ST_READ: begin
        lat_d   = LAT_W'(READ_LAT - 1);
        state_d = ST_LAT;
      end
      ST_LAT: begin
        if (lat_q != '0) begin
          lat_d = lat_q - LAT_W'(1);
        end else if (stat_ready) begin
          est_upd = 1'b1;
          if (stat_lock) begin
            res_d   = RES_PROTECT;
            state_d = ST_CLR;
          end else begin
            res_d   = RES_OK;
            state_d = ST_FIN;
          end
        end else if (z_q == Z_LIMIT) begin
          res_d   = RES_TIMEOUT;
          state_d = ST_FIN;
        end else begin
          z_d       = z_q + Z_W'(1);
          tmr_start = 1'b1;
          tmr_count = WWT_W'(1);
          state_d   = ST_GAP;
        end
      end
      ST_GAP:  if (tmr_exp) state_d = ST_READ;
      ST_CLR:  state_d = ST_RDSR;
      ST_RDSR: state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      setup_q <= '0;
      z_q     <= '0;
      lat_q   <= '0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      setup_q <= setup_d;
      z_q     <= z_d;
      lat_q   <= lat_d;
      res_q   <= res_d;
    end
  end

  nwp_us_timer #(.CYC_PER_US(CYC_PER_US), .CNT_W(WWT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(tmr_start),
    .count_i(tmr_count), .expire_o(tmr_exp)
  );

  nwp_wwt_est #(.WWT_W(WWT_W), .WWT_INIT(WWT_INIT)) u_est (
    .clk(clk), .rst_n(rst_n), .upd_i(est_upd),
    .none_i(z_q == '0), .many_i(z_q > Z_W'(1)), .wwt_o(wwt_us)
  );

  always_comb begin
    unique case (state_q)
      ST_SETUP: fl_wdata = {{(DW-8){1'b0}}, setup_q};
      ST_CLR:   fl_wdata = {{(DW-8){1'b0}}, OP_CLR_STAT};
      ST_RDSR:  fl_wdata = {{(DW-8){1'b0}}, OP_RD_STAT};
      default:  fl_wdata = data_q;
    endcase
  end

  assign fl_we   = (state_q == ST_SETUP) || (state_q == ST_DATA) ||
                   (state_q == ST_CLR)   || (state_q == ST_RDSR);
  assign fl_re   = (state_q == ST_READ);
  assign fl_addr = addr_q;
  assign vpp_en  = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_FIN);
  assign result  = res_q;

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re)); // R6
  AST_SUPPLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> vpp_en); // R4
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    z_q <= Z_LIMIT); // R7
  AST_DATA_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |=> (fl_we && fl_addr == $past(fl_addr))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R10
endmodule

// File: tb/nor_word_prog_tb.sv
module nor_word_prog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int CPU = 4;
  localparam int TO_US = 6;
  localparam int WW = 4;
  localparam int WINIT = 3;
  localparam int RLAT = 2;

  logic clk, rst_n;
  logic req_valid;
  logic [1:0] req_mode;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic busy, done, vpp_en, fl_we, fl_re;
  logic [1:0] result;
  logic [WW-1:0] wwt_us;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;

  nor_word_prog #(.AW(AW), .DW(DW), .CYC_PER_US(CPU), .TIMEOUT_US(TO_US),
    .WWT_W(WW), .WWT_INIT(WINIT), .READ_LAT(RLAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .result(result), .wwt_us(wwt_us), .vpp_en(vpp_en), .fl_we(fl_we),
    .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // flash model: status valid only RLAT cycles after the strobe cycle
  int since = 255;
  int polls_total = 0;
  int poll_base = 0;
  int nr_cfg = 0;
  bit lock_cfg = 0;
  logic [7:0] st_val;
  always @(posedge clk) begin
    if (fl_re) begin
      since <= 1;
      polls_total <= polls_total + 1;
    end else if (since < 255) begin
      since <= since + 1;
    end
  end
  assign st_val = ((polls_total - poll_base) > nr_cfg) ?
                  (8'h80 | (lock_cfg ? 8'h02 : 8'h00)) : 8'h00;
  assign fl_rdata = (since == RLAT) ? {8'h00, st_val} : 16'h0000;

  // bus monitor
  logic [DW-1:0] we_dat [256];
  logic [AW-1:0] we_adr [256];
  int we_cyc [256];
  int re_cyc [256];
  int we_tot = 0, re_tot = 0, done_tot = 0, vpp_bad = 0;
  int vpp_first = -1;
  logic [1:0] last_res;
  logic last_vpp;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (vpp_en && vpp_first < 0) vpp_first = cyc;
    if (!busy) vpp_first = -1;
    if (fl_we) begin
      we_dat[we_tot[7:0]] = fl_wdata;
      we_adr[we_tot[7:0]] = fl_addr;
      we_cyc[we_tot[7:0]] = cyc;
      if (!vpp_en || vpp_first < 0 || (we_tot > 0 && 0 == 1) ) vpp_bad = vpp_bad + 1;
      we_tot = we_tot + 1;
    end
    if (fl_re) begin
      re_cyc[re_tot[7:0]] = cyc;
      re_tot = re_tot + 1;
    end
    if (done) begin
      done_tot = done_tot + 1;
      last_res = result;
      last_vpp = vpp_en;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] mode, input logic [AW-1:0] addr,
                        input logic [DW-1:0] data, input int nr, input bit lock,
                        input bit poke);
    int wb, rb, db, vb, w0, exp_w, polls, to, exp_res, nwe, gap, setup, lim;
    bit ok;
    @(negedge clk);
    wb = we_tot; rb = re_tot; db = done_tot; vb = vpp_bad;
    w0 = int'(wwt_us);
    poll_base = polls_total; nr_cfg = nr; lock_cfg = lock;
    req_valid = 1'b1; req_mode = mode; req_addr = addr; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      chk("R10", int'(busy), 1);
      req_valid = 1'b1; req_mode = 2'd0; req_data = 16'hDEAD;
      @(negedge clk);
      req_valid = 1'b0;
    end
    lim = 0;
    while (done_tot == db && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    if (lim >= 3000) chk("R10 watchdog", 0, 1);
    repeat (poke ? 100 : 8) @(negedge clk);
    chk("R10", done_tot - db, 1);
    chk("R4", int'(last_vpp), 0);
    chk("R4", vpp_bad - vb, 0);
    chk("R1", int'(busy), 0);
    if (mode > 2'd1) begin
      chk("R2", int'(last_res), 3);
      chk("R2", we_tot - wb, 0);
      chk("R2", re_tot - rb, 0);
      chk("R2", int'(wwt_us), w0);
    end else begin
      to = (nr > TO_US) ? 1 : 0;
      polls = to ? TO_US + 1 : nr + 1;
      exp_res = to ? 1 : (lock ? 2 : 0);
      nwe = (lock && !to) ? 4 : 2;
      setup = (mode == 2'd1) ? 'hC0 : 'h40;
      chk(to ? "R7" : (lock ? "R9" : "R10"), int'(last_res), exp_res);
      chk("R11", re_tot - rb, polls);
      chk("R3", we_tot - wb, nwe);
      chk("R2", int'(we_dat[wb[7:0]]), setup);
      chk("R3", int'(we_dat[(wb + 1) % 256]), int'(data));
      for (int i = 0; i < nwe; i++)
        chk("R3", int'(we_adr[(wb + i) % 256]), int'(addr & ~12'h1));
      if (lock && !to) begin
        chk("R9", int'(we_dat[(wb + 2) % 256]), 'h50);
        chk("R9", int'(we_dat[(wb + 3) % 256]), 'h70);
      end
      gap = re_cyc[rb[7:0]] - we_cyc[(wb + 1) % 256];
      ok = (gap >= w0 * CPU) && (gap <= w0 * CPU + 4);
      chk("R5", int'(ok), 1);
      if (polls > 1) begin
        gap = re_cyc[(rb + 1) % 256] - re_cyc[rb[7:0]];
        ok = (gap >= CPU) && (gap <= CPU + RLAT + 4);
        chk("R6", int'(ok), 1);
      end
      exp_w = w0;
      if (!to) begin
        if (polls == 1) exp_w = (w0 > 1) ? w0 - 1 : 1;
        else if (polls > 2) exp_w = (w0 < 15) ? w0 + 1 : 15;
      end
      chk(to ? "R7" : "R8", int'(wwt_us), exp_w);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0;
    req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", int'(busy), 0);
    chk("R1", int'(vpp_en), 0);
    chk("R1", int'(fl_we | fl_re | done), 0);
    chk("R1", int'(wwt_us), WINIT);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_op(2'd0, 12'h123, 16'hA5C3, 0, 0, 0);   // R8 decrement 3->2
    run_op(2'd1, 12'h040, 16'h1234, 1, 0, 0);   // R2 OTP, two reads, hold
    run_op(2'd0, 12'h3FF, 16'h0F0F, 3, 0, 0);   // R6 R8 increment 2->3
    run_op(2'd0, 12'h010, 16'h5555, 0, 0, 0);   // 3->2
    run_op(2'd0, 12'h011, 16'hAAAA, 0, 0, 0);   // 2->1
    run_op(2'd0, 12'h012, 16'h0001, 0, 0, 0);   // R8 floor at 1
    run_op(2'd0, 12'h201, 16'hBEEF, 0, 1, 0);   // R9 lock, first read
    run_op(2'd1, 12'h202, 16'hCAFE, 2, 1, 0);   // R9 lock, three reads
    run_op(2'd0, 12'h300, 16'h7777, 99, 0, 0);  // R7 timeout
    run_op(2'd0, 12'h301, 16'h8888, TO_US, 0, 0); // R7 ready on last read
    run_op(2'd2, 12'h100, 16'h1111, 0, 0, 0);   // R2 invalid
    run_op(2'd3, 12'h100, 16'h2222, 0, 0, 0);   // R2 invalid
    run_op(2'd0, 12'h0A1, 16'h4321, 2, 0, 1);   // R10 request while busy
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule